// File: doc/BRIEF.md
# Multi-line scanner interrupt controller

This block watches a set of serial lines for service requests and turns them into one interrupt for a host. A round-robin scanner looks at each line's receive-ready and transmit-ready request. When it finds a line needing service, it halts on that line and records a receive or transmit cause. While it is halted it raises the interrupt if a nonzero channel has been programmed. The scanner stays halted until host software services the line through the command port, which restarts it. The line UARTs are outside the block: each one appears as a request pin pair plus an 8-bit receive character. Transmit characters leave the block as a one-cycle write strobe.

The block keeps one active-transmitter flag per line. A transmit request from a line whose flag is clear is never selected. The host uses a single command stream with four operations: control write, data-in read, data-out write and status read. Reads return a word on a response stream. While a response is waiting, the command port is not ready. Back-pressure on the response stream therefore stalls the next command and never drops or reorders a response.

Top module: `line_scan_irq`

## Requirements
- R1: While the scanner runs, it stops on the first line with a selectable request, searching upward from the line after the last one it stopped on and wrapping at NUM_LINES. The stop is visible in the cycle after the request is first seen.
- R2: When a selected line has both requests, it stops with the receive cause. The receive cause (status bit 4) and the transmit cause (status bit 3) are never both set.
- R3: A transmit request from a line whose active flag is clear is ignored. The scanner neither stops nor raises the interrupt for it.
- R4: `irq` is high exactly while the scanner is halted and the channel is nonzero. With channel 0 the causes are still recorded.
- R5: A data-in read (op 1) returns a word with the character in bits 7:0, the receive cause in bit 8 and the halted line in bits 13:9. If the scanner is halted on a receive, the read clears that cause and restarts scanning.
- R6: A data-out write (op 2) targets the line in bits 13:9 when bit 14 (use-line) is set and that line is below NUM_LINES. Otherwise it targets the line of a transmit halt. If the use-line number equals the transmit-halt line, the write restarts scanning. With neither condition met, the write does nothing.
- R7: A data-out write with bit 8 (transmitter off) set clears the target's active flag and sends nothing. Otherwise it sets the flag and, in the next cycle, pulses `tx_valid` with the target line and the character from bits 7:0.
- R8: A control write (op 0) without bit 4 loads the channel from bits 2:0. If bit 3 (restart) is also set, it clears both causes and resumes scanning.
- R9: A control write with bit 4 (reset) set pulses `line_mrst` for one cycle. It clears the channel, both causes, the round-robin pointer and every active flag.
- R10: A status read (op 3) returns the channel in bits 2:0, the transmit cause in bit 3, the receive cause in bit 4 and the halted state in bit 5, with all other bits zero.
- R11: `cmd_ready` is low while a response is pending. A pending response holds `rsp_valid` and `rsp_data` stable until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 control, 1 data-in, 2 data-out, 3 status |
| cmd_data | input | 16 | Command word |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Host takes response |
| rsp_data | output | 16 | Data-in or status word |
| rx_req | input | NUM_LINES | Per-line receive-ready request |
| tx_req | input | NUM_LINES | Per-line transmit-ready request |
| rx_data | input | NUM_LINES*8 | Per-line received character, line k in bits 8k+7:8k |
| tx_valid | output | 1 | One-cycle write to a line's transmit register |
| tx_line | output | $clog2(NUM_LINES) | Line for tx_valid |
| tx_char | output | 8 | Character for tx_valid |
| line_mrst | output | 1 | One-cycle master reset to all lines (they reload defaults) |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is tried with single requests, simultaneous requests on two lines, and both requests on one line. Together these separate a fixed-priority scan from the round-robin search and show which cause wins. Data-out writes cover four cases: use-line on a running scanner, the halted line without use-line, a line number out of range, and no halt at all. These separate the three target outcomes and show whether the active flag gates later transmit requests. Channel 0 against a nonzero channel shows that the causes are recorded while the interrupt stays quiet. A stalled response stream and a control reset with a pending active line cover the handshake and the clearing rules.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    OP_CTRL = 2'd0,
    OP_DIN  = 2'd1,
    OP_DOUT = 2'd2,
    OP_STAT = 2'd3
  } scan_op_e;

  localparam int WORD_W     = 16;
  localparam int CHAR_W     = 8;
  localparam int LFIELD_W   = 5;
  // control word
  localparam int CT_RESTART = 3;
  localparam int CT_RESET   = 4;
  // data-out word
  localparam int DO_OFF     = 8;
  localparam int DO_LINE    = 9;
  localparam int DO_USE     = 14;
  // data-in word
  localparam int DI_RX      = 8;
  localparam int DI_LINE    = 9;
  // status word
  localparam int ST_TX      = 3;
  localparam int ST_RX      = 4;
  localparam int ST_HALT    = 5;
endpackage

// File: rtl/scan_rr_pick.sv
module scan_rr_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] pick
);
  // search starts one past the last winner and wraps
  always_comb begin
    int j;
    hit  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last) + k) % N;
      if (!hit && req[j]) begin
        hit  = 1'b1;
        pick = IW'(j);
      end
    end
  end
endmodule

// File: rtl/scan_line_flags.sv
module scan_line_flags #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_line,
  input  logic          wr_val,
  output logic [N-1:0]  active
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 active[g] <= 1'b0;
      else if (clr_all)                           active[g] <= 1'b0;
      else if (wr_en && wr_line == IW'(g))        active[g] <= wr_val;
    end
  end
endmodule

// File: rtl/line_scan_irq.sv
module line_scan_irq
  import scan_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IW        = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [15:0]               cmd_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [15:0]               rsp_data,
  input  logic [NUM_LINES-1:0]      rx_req,
  input  logic [NUM_LINES-1:0]      tx_req,
  input  logic [NUM_LINES*8-1:0]    rx_data,
  output logic                      tx_valid,
  output logic [IW-1:0]             tx_line,
  output logic [7:0]                tx_char,
  output logic                      line_mrst,
  output logic                      irq
);
  logic [2:0]           chan;
  logic                 rx_f, tx_f;
  logic [IW-1:0]        cur, last;
  logic [NUM_LINES-1:0] active, eligible;
  logic                 found;
  logic [IW-1:0]        pick;
  logic                 halted, acc;
  scan_op_e             op;

  // decoded command fields
  logic                 ctl_reset, ctl_restart;
  logic                 d_use, d_off, d_line_ok, d_same, d_by_word, d_hit;
  logic [IW-1:0]        d_line, d_target;
  logic [WORD_W-1:0]    din_word, stat_word;

  assign halted    = rx_f | tx_f;
  assign irq       = halted && (chan != 3'd0);
  assign cmd_ready = !rsp_valid;
  assign acc       = cmd_valid && cmd_ready;
  assign op        = scan_op_e'(cmd_op);
  assign eligible  = rx_req | (tx_req & active);

  scan_rr_pick #(.N(NUM_LINES), .IW(IW)) u_pick (
    .req(eligible), .last(last), .hit(found), .pick(pick)
  );

  assign ctl_reset   = acc && op == OP_CTRL && cmd_data[CT_RESET];
  assign ctl_restart = cmd_data[CT_RESTART];

  assign d_use     = cmd_data[DO_USE];
  assign d_off     = cmd_data[DO_OFF];
  assign d_line_ok = int'(cmd_data[DO_LINE +: LFIELD_W]) < NUM_LINES;
  assign d_line    = cmd_data[DO_LINE +: IW];
  assign d_same    = tx_f && (d_line == cur);
  assign d_by_word = d_use && d_line_ok && !d_same;
  assign d_target  = d_by_word ? d_line : cur;
  assign d_hit     = acc && op == OP_DOUT && (d_by_word || tx_f);

  always_comb begin
    din_word = '0;
    din_word[CHAR_W-1:0]              = rx_data[int'(cur)*CHAR_W +: CHAR_W];
    din_word[DI_RX]                   = rx_f;
    din_word[DI_LINE +: LFIELD_W]     = LFIELD_W'(cur);
    stat_word = '0;
    stat_word[2:0]    = chan;
    stat_word[ST_TX]  = tx_f;
    stat_word[ST_RX]  = rx_f;
    stat_word[ST_HALT]= halted;
  end

  scan_line_flags #(.N(NUM_LINES), .IW(IW)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_all(ctl_reset),
    .wr_en(d_hit), .wr_line(d_target), .wr_val(!d_off), .active(active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan <= '0; rx_f <= 1'b0; tx_f <= 1'b0; cur <= '0; last <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0;
      tx_valid <= 1'b0; tx_line <= '0; tx_char <= '0; line_mrst <= 1'b0;
    end else begin
      line_mrst <= 1'b0;
      tx_valid  <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      // scanner: halt on the next selectable line
      if (!halted && found) begin
        cur  <= pick;
        last <= pick;
        rx_f <= rx_req[pick];
        tx_f <= !rx_req[pick];
      end
      // host command (later assignments take precedence)
      if (acc) begin
        unique case (op)
          OP_CTRL: begin
            if (cmd_data[CT_RESET]) begin
              chan <= '0; rx_f <= 1'b0; tx_f <= 1'b0; last <= '0;
              line_mrst <= 1'b1;
            end else begin
              chan <= cmd_data[2:0];
              if (ctl_restart) begin rx_f <= 1'b0; tx_f <= 1'b0; end
            end
          end
          OP_DIN: begin
            rsp_valid <= 1'b1;
            rsp_data  <= din_word;
            if (rx_f) rx_f <= 1'b0;
          end
          OP_DOUT: begin
            if (d_hit) begin
              if (!d_by_word) tx_f <= 1'b0;
              if (!d_off) begin
                tx_valid <= 1'b1;
                tx_line  <= d_target;
                tx_char  <= cmd_data[CHAR_W-1:0];
              end
            end
          end
          OP_STAT: begin
            rsp_valid <= 1'b1;
            rsp_data  <= stat_word;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  cause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rx_f && tx_f));
  // R5
  din_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_DIN && rx_f) |=> !rx_f);
  // R7
  tx_halt_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_f |-> active[cur]);
  // R9
  mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_mrst |-> (active == '0 && chan == 3'd0 && !halted));
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/test_line_scan_irq.sv
module test_line_scan_irq;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [15:0] cmd_data = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [N-1:0] rx_req = '0, tx_req = '0;
  logic [N*8-1:0] rx_data;
  logic tx_valid, line_mrst, irq;
  logic [3:0] tx_line;
  logic [7:0] tx_char;

  int total = 0, bad = 0, mrst_seen = 0;
  logic [15:0] rsp_q[$];
  string       rsp_tag[$];
  logic [11:0] tx_q[$];

  always #2 clk = ~clk;

  line_scan_irq #(.NUM_LINES(N)) i_line_scan_irq (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_data,
    .rsp_valid, .rsp_ready, .rsp_data, .rx_req, .tx_req, .rx_data,
    .tx_valid, .tx_line, .tx_char, .line_mrst, .irq);

  for (genvar g = 0; g < N; g++) begin : g_rx
    assign rx_data[g*8 +: 8] = 8'(8'h30 + g);
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dinw(int line, bit rx);
    return 16'((line << 9) | (int'(rx) << 8) | (8'h30 + line));
  endfunction

  // monitor: compare outputs against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (rsp_q.size() == 0) check("R11 unexpected response", rsp_data, 16'hxxxx);
      else check(rsp_tag.pop_front(), rsp_data, rsp_q.pop_front());
    end
    if (rst_n && tx_valid) begin
      if (tx_q.size() == 0) check("R7 unexpected tx", {tx_line, tx_char}, 16'hxxxx);
      else check("R7 tx item", {4'h0, tx_line, tx_char}, {4'h0, tx_q.pop_front()});
    end
    if (rst_n && line_mrst) mrst_seen++;
  end

  task automatic send(logic [1:0] op, logic [15:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic read(logic [1:0] op, logic [15:0] exp, string tag);
    rsp_q.push_back(exp); rsp_tag.push_back(tag);
    send(op, exp == exp ? 16'h0 : 16'h0);
  endtask

  task automatic dout(bit use_line, int line, bit off, logic [7:0] ch, bit expect_tx, int exp_line);
    if (expect_tx) tx_q.push_back({4'(exp_line), ch});
    send(2'd2, 16'((int'(use_line) << 14) | (line << 9) | (int'(off) << 8) | ch));
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    check("R4 reset irq", 16'(irq), 16'h0);
    read(2'd3, 16'h0000, "R10 reset status");
    send(2'd0, 16'h0005 | 16'h0008);                  // R8 channel 5 + restart
    read(2'd3, 16'h0005, "R8 channel loaded");

    rx_req[3] = 1'b1; cyc(2);
    check("R4 irq on rx halt", 16'(irq), 16'h1);
    read(2'd3, 16'h0035, "R10 rx halt status");
    read(2'd1, dinw(3, 1), "R5 data-in line 3");
    rx_req[3] = 1'b0; cyc(2);
    check("R5 restart drops irq", 16'(irq), 16'h0);

    tx_req[7] = 1'b1; cyc(5);
    check("R3 inactive tx ignored", 16'(irq), 16'h0);
    dout(1, 7, 0, 8'h55, 1, 7);                       // R6 use-line, R7 activate
    cyc(2);
    read(2'd3, 16'h002D, "R3 active tx halts");
    dout(0, 0, 0, 8'h66, 1, 7);                       // R6 halted-line target
    tx_req[7] = 1'b0; cyc(2);
    check("R6 dout restarts", 16'(irq), 16'h0);

    rx_req[7] = 1'b1; tx_req[7] = 1'b1; cyc(2);
    read(2'd3, 16'h0035, "R2 rx wins over tx");
    read(2'd1, dinw(7, 1), "R5 data-in line 7");
    rx_req[7] = 1'b0; tx_req[7] = 1'b0; cyc(2);

    rx_req[2] = 1'b1; rx_req[9] = 1'b1; cyc(2);
    read(2'd1, dinw(9, 1), "R1 round-robin picks 9 after 7");
    rx_req[9] = 1'b0; cyc(2);
    read(2'd1, dinw(2, 1), "R1 then wraps to 2");
    rx_req[2] = 1'b0; cyc(2);

    send(2'd0, 16'h0008);                             // channel 0
    rx_req[4] = 1'b1; cyc(3);
    check("R4 channel 0 quiet", 16'(irq), 16'h0);
    read(2'd3, 16'h0030, "R4 cause recorded on channel 0");
    read(2'd1, dinw(4, 1), "R5 data-in line 4");
    rx_req[4] = 1'b0; cyc(2);

    send(2'd0, 16'h000A);                             // channel 2
    dout(1, 7, 1, 8'h99, 0, 0);                       // R7 transmitter off
    tx_req[7] = 1'b1; cyc(4);
    check("R7 off line not halting", 16'(irq), 16'h0);
    read(2'd3, 16'h0002, "R7 off status");
    tx_req[7] = 1'b0;
    dout(0, 0, 0, 8'h77, 0, 0);                       // R6 no-op, not halted
    dout(1, 20, 0, 8'h12, 0, 0);                      // R6 out-of-range line
    cyc(3);

    rsp_ready = 1'b0;
    read(2'd3, 16'h0002, "R11 held response");
    cyc(3);
    check("R11 cmd_ready low", 16'(cmd_ready), 16'h0);
    check("R11 rsp_valid held", 16'(rsp_valid), 16'h1);
    rsp_ready = 1'b1; cyc(2);

    dout(1, 5, 0, 8'h11, 1, 5);
    send(2'd0, 16'h0013);                             // R9 reset
    read(2'd3, 16'h0000, "R9 channel cleared");
    tx_req[5] = 1'b1; cyc(4);
    read(2'd3, 16'h0000, "R9 active flags cleared");
    tx_req[5] = 1'b0; cyc(4);

    check("R9 one mrst pulse", 16'(mrst_seen), 16'h1);
    check("R11 all responses seen", 16'(rsp_q.size()), 16'h0);
    check("R7 all tx items seen", 16'(tx_q.size()), 16'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule